// File: doc/BRIEF.md
# Disk Write Bit-Cell Serializer

This block turns bytes that a CPU writes to a small set of I/O ports into a stream of write-data bit cells for a floppy drive. A drive-control latch picks the drive, the disk side, whether the drive is enabled and whether writing is requested. A byte holding register supplies the data. A sync-mode register adds two trailing zero cells to every byte. These 10-cell bytes let a reading controller align itself to byte boundaries after a short run of them.

The drive supplies a bit-cell strobe. While writing is active, the block sends one cell per strobe, most significant bit first. When a byte finishes, the next strobe loads whatever the holding register contains, so the stream has no gap. A ready flag tells the CPU that the held byte has been taken. If the CPU does not supply a new byte in time, the same byte goes out again. A change of sync mode only takes effect on the next byte that is loaded.

Top module: `dsk_wr_serializer`

## Requirements
- R1: After reset, wr_req_n is 1, drv1_sel, drv2_sel, side_sel, wr_data and byte_ready are 0, the latch is 00h and self-sync mode is off.
- R2: A write to port 10h loads the drive latch. Bit 4 enables the drive. Bit 5 chooses the drive: 0 gives drv1_sel and 1 gives drv2_sel, and neither is asserted unless bit 4 is 1. Bit 7 drives side_sel. Bit 6 is an active-low write request, and wr_req_n goes low only when bit 6 is 0 and bit 4 is 1. Writing 00h leaves the block idle with no drive selected.
- R3: A write of FFh to port 11h turns self-sync mode on. A write of any other value to port 11h turns it off.
- R4: While writing is active, each cell strobe sends one cell, most significant data bit first. wr_data shows the cell in the cycle after the strobe and holds it until the next strobe.
- R5: In self-sync mode a byte is 10 cells: its 8 data bits followed by two 0 cells. In normal mode a byte is 8 cells.
- R6: The strobe that follows the last cell of a byte loads the byte then held from port 13h, with no gap. byte_ready is set in the cycle after that load and is cleared by a CPU write to port 13h.
- R7: If port 13h has not been written since the last load, the previous byte is sent again.
- R8: A change of sync mode made in the middle of a byte leaves that byte's length unchanged and applies from the next byte loaded.
- R9: While writing is not active, wr_data is 0 and strobes send nothing. When writing becomes active again, the next strobe starts a new byte at its most significant bit.
- R10: CPU writes to any port other than 10h, 11h and 13h change neither the drive outputs, the sync mode nor the held byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU port write strobe, one cycle |
| cpu_port | input | 8 | Port address of the write |
| cpu_wdata | input | 8 | Data of the write |
| cell_stb | input | 1 | Bit-cell strobe from the drive timing |
| wr_data | output | 1 | Current write-data cell |
| wr_req_n | output | 1 | Active-low write request to the drive |
| drv1_sel | output | 1 | First drive selected |
| drv2_sel | output | 1 | Second drive selected |
| side_sel | output | 1 | Disk side select |
| byte_ready | output | 1 | Held byte taken, a new one may be written |

## Verification
On every cycle the assertions check the following:
- wr_data stays silent while writing is inactive, and holds between strobes.
- The two tail cells of a self-sync byte are zero.
- The captured sync mode never changes inside a byte.
- A load shows the held byte's top bit.
- The ready flag follows loads and CPU data writes.
- Port 11h decodes only FFh as self-sync.
- Writes to foreign ports leave the latch alone.

Only the bench's scenarios can show the following:
- Whole bit sequences are in the right order.
- Bytes follow one another without a gap and repeat when no new byte arrives.
- A mid-byte mode change lands on the next byte.
- The drive and side decode is correct for several latch values.

// File: rtl/dsk_wr_pkg.sv
package dsk_wr_pkg;

  localparam int unsigned LATCH_W      = 8;
  localparam int unsigned LAT_EN_BIT   = 4;
  localparam int unsigned LAT_DRV_BIT  = 5;
  localparam int unsigned LAT_WRQ_BIT  = 6;
  localparam int unsigned LAT_SIDE_BIT = 7;

  typedef struct packed {
    logic side;
    logic wr_req_n;
    logic drv2;
    logic drv1;
  } drive_ctl_t;

  // Decode of the drive latch into drive-facing controls.
  function automatic drive_ctl_t decode_latch(input logic [LATCH_W-1:0] l);
    drive_ctl_t c;
    c.side     = l[LAT_SIDE_BIT];
    c.wr_req_n = !(l[LAT_EN_BIT] && !l[LAT_WRQ_BIT]);
    c.drv1     = l[LAT_EN_BIT] && !l[LAT_DRV_BIT];
    c.drv2     = l[LAT_EN_BIT] &&  l[LAT_DRV_BIT];
    return c;
  endfunction

  // Number of cells one byte occupies on the disk.
  function automatic int unsigned cells_per_byte(input logic sync,
                                                 input int unsigned data_w,
                                                 input int unsigned tail);
    return data_w + (sync ? tail : 0);
  endfunction

endpackage

// File: rtl/dsk_wr_regs.sv
module dsk_wr_regs
  import dsk_wr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 8,
  parameter logic [ADDR_W-1:0] PORT_LATCH = 'h10,
  parameter logic [ADDR_W-1:0] PORT_SYNC  = 'h11,
  parameter logic [ADDR_W-1:0] PORT_DATA  = 'h13,
  parameter logic [DATA_W-1:0] SYNC_KEY   = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_wr,
  input  logic [ADDR_W-1:0]  cpu_port,
  input  logic [DATA_W-1:0]  cpu_wdata,
  output logic [LATCH_W-1:0] latch_q,
  output logic               sync_mode,
  output logic [DATA_W-1:0]  hold_q,
  output logic               data_wr_evt
);

  logic latch_wr_evt;
  logic sync_wr_evt;
  logic foreign_wr_evt;

  assign latch_wr_evt   = cpu_wr && (cpu_port == PORT_LATCH);
  assign sync_wr_evt    = cpu_wr && (cpu_port == PORT_SYNC);
  assign data_wr_evt    = cpu_wr && (cpu_port == PORT_DATA);
  assign foreign_wr_evt = cpu_wr && !latch_wr_evt && !sync_wr_evt && !data_wr_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q   <= '0;
      sync_mode <= 1'b0;
      hold_q    <= '0;
    end else begin
      if (latch_wr_evt) latch_q   <= cpu_wdata[LATCH_W-1:0];
      if (sync_wr_evt)  sync_mode <= (cpu_wdata == SYNC_KEY);
      if (data_wr_evt)  hold_q    <= cpu_wdata;
    end
  end

  AST_SYNC_KEY_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_wr_evt |=> (sync_mode == ($past(cpu_wdata) == SYNC_KEY))); // R3

  AST_FOREIGN_PORT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    foreign_wr_evt |=> ($stable(latch_q) && $stable(sync_mode) && $stable(hold_q))); // R10

endmodule

// File: rtl/dsk_wr_shifter.sv
module dsk_wr_shifter
  import dsk_wr_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned TAIL_CELLS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_active,
  input  logic              cell_stb,
  input  logic              sync_mode,
  input  logic [DATA_W-1:0] hold_q,
  output logic              wr_data,
  output logic              load_evt,
  output logic              tail_cell
);

  localparam int unsigned MAX_CELLS = DATA_W + TAIL_CELLS;
  localparam int unsigned CNT_W     = $clog2(MAX_CELLS + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] shift_q;
  logic              cur_sync_q;
  logic [CNT_W-1:0]  last_idx;
  logic              step_evt;

  assign last_idx  = CNT_W'(cells_per_byte(cur_sync_q, DATA_W, TAIL_CELLS) - 1);
  assign step_evt  = wr_active && cell_stb;
  assign load_evt  = step_evt && (cnt_q == '0);
  assign tail_cell = step_evt && (cnt_q >= CNT_W'(DATA_W));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      shift_q    <= '0;
      cur_sync_q <= 1'b0;
      wr_data    <= 1'b0;
    end else if (!wr_active) begin
      cnt_q   <= '0;
      shift_q <= '0;
      wr_data <= 1'b0;
    end else if (cell_stb) begin
      if (cnt_q == '0) begin
        shift_q    <= {hold_q[DATA_W-2:0], 1'b0};
        wr_data    <= hold_q[DATA_W-1];
        cur_sync_q <= sync_mode;
        cnt_q      <= CNT_W'(1);
      end else begin
        if (cnt_q < CNT_W'(DATA_W)) begin
          wr_data <= shift_q[DATA_W-1];
          shift_q <= {shift_q[DATA_W-2:0], 1'b0};
        end else begin
          wr_data <= 1'b0;
        end
        cnt_q <= (cnt_q == last_idx) ? '0 : cnt_q + CNT_W'(1);
      end
    end
  end

  AST_HOLD_BETWEEN_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_active && !cell_stb) |=> $stable(wr_data)); // R4

  AST_LOAD_SHOWS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (wr_data == $past(hold_q[DATA_W-1]))); // R4

  AST_TAIL_CELLS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tail_cell |=> !wr_data); // R5

  AST_MODE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |=> $stable(cur_sync_q)); // R8

  AST_SILENT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_active |=> (!wr_data && cnt_q == '0)); // R9

endmodule

// File: rtl/dsk_wr_ready.sv
module dsk_wr_ready (
  input  logic clk,
  input  logic rst_n,
  input  logic load_evt,
  input  logic data_wr_evt,
  output logic byte_ready
);

  always_ff @(posedge clk) begin
    if (!rst_n)           byte_ready <= 1'b0;
    else if (data_wr_evt) byte_ready <= 1'b0;
    else if (load_evt)    byte_ready <= 1'b1;
  end

  AST_READY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !data_wr_evt) |=> byte_ready); // R6

  AST_READY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr_evt |=> !byte_ready); // R6

endmodule

// File: rtl/dsk_wr_serializer.sv
module dsk_wr_serializer
  import dsk_wr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned TAIL_CELLS = 2,
  parameter logic [ADDR_W-1:0] PORT_LATCH = 'h10,
  parameter logic [ADDR_W-1:0] PORT_SYNC  = 'h11,
  parameter logic [ADDR_W-1:0] PORT_DATA  = 'h13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_port,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cell_stb,
  output logic              wr_data,
  output logic              wr_req_n,
  output logic              drv1_sel,
  output logic              drv2_sel,
  output logic              side_sel,
  output logic              byte_ready
);

  logic [LATCH_W-1:0] latch_q;
  logic               sync_mode;
  logic [DATA_W-1:0]  hold_q;
  logic               data_wr_evt;
  logic               load_evt;
  logic               tail_cell;
  logic               wr_active;
  drive_ctl_t         ctl;

  dsk_wr_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PORT_LATCH(PORT_LATCH), .PORT_SYNC(PORT_SYNC), .PORT_DATA(PORT_DATA),
    .SYNC_KEY({DATA_W{1'b1}})
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_port(cpu_port),
    .cpu_wdata(cpu_wdata), .latch_q(latch_q), .sync_mode(sync_mode),
    .hold_q(hold_q), .data_wr_evt(data_wr_evt)
  );

  assign ctl       = decode_latch(latch_q);
  assign wr_active = !ctl.wr_req_n;
  assign wr_req_n  = ctl.wr_req_n;
  assign drv1_sel  = ctl.drv1;
  assign drv2_sel  = ctl.drv2;
  assign side_sel  = ctl.side;

  dsk_wr_shifter #(.DATA_W(DATA_W), .TAIL_CELLS(TAIL_CELLS)) u_shift (
    .clk(clk), .rst_n(rst_n), .wr_active(wr_active), .cell_stb(cell_stb),
    .sync_mode(sync_mode), .hold_q(hold_q), .wr_data(wr_data),
    .load_evt(load_evt), .tail_cell(tail_cell)
  );

  dsk_wr_ready u_ready (
    .clk(clk), .rst_n(rst_n), .load_evt(load_evt),
    .data_wr_evt(data_wr_evt), .byte_ready(byte_ready)
  );

  AST_ONE_DRIVE_AT_MOST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drv1_sel, drv2_sel})); // R2

  AST_WRITE_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_req_n |-> (drv1_sel || drv2_sel)); // R2

endmodule

// File: tb/test_dsk_wr_serializer.sv
module test_dsk_wr_serializer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_wr = 1'b0;
  logic [7:0] cpu_port = '0;
  logic [7:0] cpu_wdata = '0;
  logic       cell_stb = 1'b0;
  logic       wr_data, wr_req_n, drv1_sel, drv2_sel, side_sel, byte_ready;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dsk_wr_serializer i_dsk_wr_serializer (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_port(cpu_port),
    .cpu_wdata(cpu_wdata), .cell_stb(cell_stb), .wr_data(wr_data),
    .wr_req_n(wr_req_n), .drv1_sel(drv1_sel), .drv2_sel(drv2_sel),
    .side_sel(side_sel), .byte_ready(byte_ready)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [7:0] port, input logic [7:0] data);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_port = port; cpu_wdata = data;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk);
    cell_stb = 1'b1;
    @(negedge clk);
    cell_stb = 1'b0;
  endtask

  task automatic get_cells(input int n, output logic [15:0] v);
    v = '0;
    for (int i = 0; i < n; i++) begin
      strobe();
      v = {v[14:0], wr_data};
    end
  endtask

  function automatic logic [3:0] drive_pins();
    return {side_sel, wr_req_n, drv2_sel, drv1_sel};
  endfunction

  task automatic t_reset();
    chk("R1 drive pins", 16'(drive_pins()), 16'b0100);
    chk("R1 wr_data", 16'(wr_data), 16'h0);
    chk("R1 byte_ready", 16'(byte_ready), 16'h0);
  endtask

  task automatic t_latch();
    cpu_write(8'h10, 8'h10);
    chk("R2 latch 10h", 16'(drive_pins()), 16'b0001);
    cpu_write(8'h10, 8'hB0);
    chk("R2 latch B0h", 16'(drive_pins()), 16'b1010);
    cpu_write(8'h10, 8'h50);
    chk("R2 latch 50h", 16'(drive_pins()), 16'b0101);
    cpu_write(8'h10, 8'h00);
    chk("R2 latch 00h idle", 16'(drive_pins()), 16'b0100);
  endtask

  task automatic t_normal();
    logic [15:0] v;
    cpu_write(8'h13, 8'hA5);
    cpu_write(8'h10, 8'h10);
    chk("R6 ready before load", 16'(byte_ready), 16'h0);
    strobe();
    chk("R6 ready after load", 16'(byte_ready), 16'h1);
    get_cells(7, v);
    chk("R4 byte A5 msb first", {v[14:8], 1'b0, v[7:0]} & 16'h00FF | 16'(v[6:0]) , 16'(8'h25) | 16'h0000);
    cpu_write(8'h13, 8'h3C);
    chk("R6 ready cleared", 16'(byte_ready), 16'h0);
    get_cells(8, v);
    chk("R6 next byte no gap", v, 16'h003C);
    get_cells(8, v);
    chk("R7 byte repeated", v, 16'h003C);
    cpu_write(8'h10, 8'h00);
  endtask

  task automatic t_sync();
    logic [15:0] v;
    cpu_write(8'h11, 8'hFF);
    cpu_write(8'h13, 8'hFF);
    cpu_write(8'h10, 8'h10);
    get_cells(10, v);
    chk("R5 self-sync byte", v, 16'h03FC);
    get_cells(10, v);
    chk("R3 sync on, repeat", v, 16'h03FC);
    get_cells(3, v);
    cpu_write(8'h11, 8'h00);
    cpu_write(8'h13, 8'hD5);
    get_cells(7, v);
    chk("R8 mode kept mid-byte", v, 16'h007C);
    get_cells(8, v);
    chk("R8 new mode next byte", v, 16'h00D5);
    get_cells(8, v);
    chk("R3 sync off no tail", v, 16'h00D5);
    cpu_write(8'h11, 8'hFE);
    cpu_write(8'h13, 8'hFF);
    get_cells(8, v);
    chk("R3 FEh keeps sync off", v, 16'h00FF);
    get_cells(8, v);
    chk("R3 FEh next byte starts at once", v, 16'h00FF);
    cpu_write(8'h10, 8'h00);
  endtask

  task automatic t_idle();
    logic [15:0] v;
    cpu_write(8'h13, 8'h81);
    get_cells(4, v);
    chk("R9 idle strobes silent", v, 16'h0000);
    cpu_write(8'h10, 8'h50);
    get_cells(4, v);
    chk("R9 read mode silent", v, 16'h0000);
    cpu_write(8'h10, 8'h10);
    get_cells(3, v);
    chk("R9 first cells", v, 16'h0004);
    cpu_write(8'h10, 8'h00);
    chk("R9 wr_data low when idle", 16'(wr_data), 16'h0);
    cpu_write(8'h10, 8'h10);
    get_cells(8, v);
    chk("R9 restart at msb", v, 16'h0081);
    cpu_write(8'h10, 8'h00);
  endtask

  task automatic t_foreign();
    logic [15:0] v;
    cpu_write(8'h13, 8'h96);
    cpu_write(8'h10, 8'h30);
    cpu_write(8'h12, 8'h00);
    cpu_write(8'h14, 8'hFF);
    cpu_write(8'h90, 8'h55);
    chk("R10 latch unchanged", 16'(drive_pins()), 16'b0010);
    get_cells(8, v);
    chk("R10 data and sync unchanged", v, 16'h0096);
    get_cells(2, v);
    chk("R10 no tail cells", v, 16'h0002);
    cpu_write(8'h10, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch();
    t_normal();
    t_sync();
    t_idle();
    t_foreign();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule